// File: doc/BRIEF.md
# Seven-to-One Three-Lane Pixel Serializer

This block turns a 21-bit parallel pixel word into three serial data lanes and one forwarded clock lane. The word holds eighteen colour bits (six each of red, green and blue) and three timing controls: line sync, frame sync and data enable. One word is taken in on each rising edge of the pixel clock.

A bit clock running at seven times the pixel rate, phase-aligned with the pixel clock, drives seven evenly spaced bit slots per pixel period. Each data lane sends seven word bits in those slots. The clock lane sends a fixed seven-slot pattern so that a receiver can find the word boundary. The frequency multiplier and the differential drivers are outside the block. The drivers are represented by single-ended outputs and one shared enable, where a low enable stands for high impedance.

An active-low power-down input disables the outputs at once. After power-down is released, and after reset, the outputs remain disabled until a complete word has been loaded, so a partial word is never sent.

Top module: `pixser_top`

## Requirements
- R1: A word present at `word_i` at a pixel-clock rising edge is sent in full during the pixel period that starts at the next pixel-clock rising edge. Words follow each other back to back with no idle periods.
- R2: Lane k (`ser_data_o[k]`) carries word bits 7k to 7k+6. Lane 0 carries bits 0 to 6, lane 1 carries bits 7 to 13 and lane 2 carries bits 14 to 20.
- R3: Within a pixel period, slot s (s = 0 to 6) of a lane carries that lane's bit 7k+s. Bits go out in ascending order, one per bit-clock cycle. Slot 0 is driven from the bit-clock edge that coincides with the pixel-clock rising edge.
- R4: During enabled periods, `ser_clk_o` sends the pattern 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period.
- R5: While `pd_n` is low, `ser_oe_o` is 0 and `ser_data_o` and `ser_clk_o` are all 0. This holds from the first sample after `pd_n` falls.
- R6: After reset, `ser_oe_o` stays 0 for the whole first pixel period. It turns 1 at the start of the second period, carrying the word sampled at the first pixel edge.
- R7: When `pd_n` rises in the middle of a pixel period, the outputs stay disabled for the rest of that period. They turn back on at the start of the next pixel period, with a complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate, rising edges aligned with pix_clk |
| pix_clk | input | 1 | Pixel clock; its rising edge samples word_i |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| pd_n | input | 1 | Active-low power-down |
| word_i | input | 21 | Parallel pixel word: colour bits and line sync, frame sync, data enable |
| ser_data_o | output | 3 | Serial data lanes, one bit per bit-clock slot |
| ser_clk_o | output | 1 | Forwarded clock lane pattern |
| ser_oe_o | output | 1 | Output enable for all lanes; 0 stands for high impedance |

## Verification
The bench builds the block with its default parameters: three data lanes and seven slots per pixel period. This is the geometry in which a 21-bit word fills every slot exactly, so each word bit is mapped to a unique lane and slot. Walking-one words and all-ones, all-zeros and alternating patterns expose any swapped lanes or reversed slot order. A pseudo-random stream checks that words follow each other back to back with the one-period latency. Power-down is entered and left in the middle of a period, which brings the mid-period disable and the restart on a whole word within reach.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

    // Default geometry: three data lanes of seven slots per pixel period.
    localparam int DEF_LANES = 3;
    localparam int DEF_SLOTS = 7;

    // Clock-lane pattern; bit s is sent in slot s.
    localparam logic [DEF_SLOTS-1:0] DEF_CLK_PATTERN = 7'b1100011;

endpackage

// File: rtl/pixser_capture.sv
module pixser_capture #(
    parameter int WORD_W = 21
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] shadow_o,
    output logic              tog_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              tog;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.word = word_i;
        cap_d.tog  = ~cap_q.tog;
    end

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign shadow_o = cap_q.word;
    assign tog_o    = cap_q.tog;

endmodule

// File: rtl/pixser_framer.sv
module pixser_framer #(
    parameter int SLOTS = 7
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic tog_i,
    output logic load_o,
    output logic oe_o
);

    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             locked;
        logic             armed;
    } frm_t;

    frm_t frm_d, frm_q;
    logic edge_seen;
    logic load;

    assign edge_seen = tog_i ^ frm_q.seen;
    assign load      = frm_q.locked && (frm_q.cnt == LAST);

    always_comb begin
        frm_d        = frm_q;
        frm_d.seen   = tog_i;
        frm_d.locked = frm_q.locked | edge_seen;
        if (load)
            frm_d.cnt = '0;
        else if (edge_seen)
            frm_d.cnt = CNT_W'(1);
        else if (frm_q.cnt == LAST)
            frm_d.cnt = '0;
        else
            frm_d.cnt = frm_q.cnt + CNT_W'(1);
        frm_d.armed = pd_n ? (frm_q.armed | load) : 1'b0;
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign load_o = load;
    assign oe_o   = frm_q.armed & pd_n;

    a_r3_slot_range: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frm_q.cnt <= LAST);

    a_r1_load_restarts_slots: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (frm_q.cnt == '0));

    a_r5_pd_disarms: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pd_n |=> !frm_q.armed);

    a_r7_arm_on_load: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(frm_q.armed) |-> $past(load));

endmodule

// File: rtl/pixser_lane.sv
module pixser_lane #(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SLOTS-1:0] par_i,
    output logic             bit_o
);

    typedef struct packed {
        logic [SLOTS-1:0] sh;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load_i)
            lane_d.sh = par_i;
        else
            lane_d.sh = {1'b0, lane_q.sh[SLOTS-1:1]};
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign bit_o = lane_q.sh[0];

    a_r2_load_first_bit: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load_i |=> (bit_o == $past(par_i[0])));

    a_r3_shift_order: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !load_i |=> (lane_q.sh[SLOTS-2:0] == $past(lane_q.sh[SLOTS-1:1])));

endmodule

// File: rtl/pixser_top.sv
module pixser_top
    import pixser_pkg::*;
#(
    parameter int               LANES       = DEF_LANES,
    parameter int               SLOTS       = DEF_SLOTS,
    parameter logic [SLOTS-1:0] CLK_PATTERN = DEF_CLK_PATTERN
) (
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   rst_n,
    input  logic                   pd_n,
    input  logic [LANES*SLOTS-1:0] word_i,
    output logic [LANES-1:0]       ser_data_o,
    output logic                   ser_clk_o,
    output logic                   ser_oe_o
);

    localparam int WORD_W = LANES * SLOTS;

    logic [WORD_W-1:0] shadow;
    logic              tog;
    logic              load;
    logic              oe;
    logic [LANES-1:0]  lane_bit;
    logic              clk_bit;

    pixser_capture #(.WORD_W(WORD_W)) u_capture (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .word_i   (word_i),
        .shadow_o (shadow),
        .tog_o    (tog)
    );

    pixser_framer #(.SLOTS(SLOTS)) u_framer (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .tog_i   (tog),
        .load_o  (load),
        .oe_o    (oe)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_data
        pixser_lane #(.SLOTS(SLOTS)) u_lane (
            .bit_clk (bit_clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .par_i   (shadow[k*SLOTS +: SLOTS]),
            .bit_o   (lane_bit[k])
        );
    end

    pixser_lane #(.SLOTS(SLOTS)) u_clk_lane (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .par_i   (CLK_PATTERN),
        .bit_o   (clk_bit)
    );

    assign ser_data_o = oe ? lane_bit : '0;
    assign ser_clk_o  = oe & clk_bit;
    assign ser_oe_o   = oe;

    a_r5_quiet_when_off: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !ser_oe_o |-> (ser_data_o == '0 && !ser_clk_o));

endmodule

// File: tb/test_pixser_top.sv
module test_pixser_top;

    localparam int LANES = 3;
    localparam int SLOTS = 7;
    localparam int W     = LANES * SLOTS;
    localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

    logic         bit_clk = 1'b0;
    logic         pix_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         pd_n    = 1'b1;
    logic [W-1:0] word_i;
    logic [LANES-1:0] ser_data_o;
    logic         ser_clk_o;
    logic         ser_oe_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] prev1, prev2;

    pixser_top i_pixser_top (
        .bit_clk    (bit_clk),
        .pix_clk    (pix_clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .word_i     (word_i),
        .ser_data_o (ser_data_o),
        .ser_clk_o  (ser_clk_o),
        .ser_oe_o   (ser_oe_o)
    );

    // 100 MHz bit clock; pixel clock at one seventh, rising edges aligned.
    initial begin
        forever begin
            for (int h = 0; h < 2 * SLOTS; h++) begin
                bit_clk = (h % 2 == 0);
                pix_clk = (h < SLOTS);
                #5;
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One pixel period: drive next word (and pd_n) just after the pixel edge,
    // then check all seven slots against the word driven two periods earlier.
    task automatic period(input logic [W-1:0] drv, input logic pd_val,
                          input bit exp_on, input string off_req);
        @(posedge pix_clk);
        #1;
        word_i = drv;
        pd_n   = pd_val;
        for (int s = 0; s < SLOTS; s++) begin
            @(negedge bit_clk);
            if (exp_on) begin
                chk(32'(ser_oe_o), 32'd1, "R1 enable");
                for (int k = 0; k < LANES; k++)
                    chk(32'(ser_data_o[k]), 32'(prev2[k*SLOTS + s]), "R2 R3 lane bit");
                chk(32'(ser_clk_o), 32'(CLK_PAT[s]), "R4 clock lane");
            end else begin
                chk(32'(ser_oe_o), 32'd0, off_req);
                chk(32'(ser_data_o), 32'd0, off_req);
                chk(32'(ser_clk_o), 32'd0, off_req);
            end
        end
        prev2 = prev1;
        prev1 = drv;
    endtask

    function automatic logic [W-1:0] next_rand(input logic [W-1:0] v);
        logic [W-1:0] x;
        x = v;
        x = x ^ (x << 5);
        x = x ^ (x >> 7);
        x = x ^ (x << 3);
        if (x == '0) x = 21'h1;
        return x;
    endfunction

    task automatic t_reset;
        word_i = 21'h15A3C9;
        prev1  = 21'h15A3C9;
        prev2  = '0;
        rst_n  = 1'b0;
        repeat (3) @(posedge pix_clk);
        #2;
        chk(32'(ser_oe_o), 32'd0, "R6 in reset");
        @(negedge pix_clk);
        rst_n = 1'b1;
        // R6: first period disabled, second carries the word held at the first edge.
        period(21'h0ABCDE, 1'b1, 1'b0, "R6 first period");
        period(21'h1FFFFF, 1'b1, 1'b1, "R6");
    endtask

    task automatic t_patterns;
        period(21'h000000, 1'b1, 1'b1, "R1");
        period(21'h0AAAAA, 1'b1, 1'b1, "R1");
        period(21'h155555, 1'b1, 1'b1, "R1");
        for (int b = 0; b < W; b++)
            period(21'(1) << b, 1'b1, 1'b1, "R2");
        period(21'h000000, 1'b1, 1'b1, "R1");
        period(21'h000000, 1'b1, 1'b1, "R1");
    endtask

    task automatic t_powerdown;
        period(21'h123456, 1'b1, 1'b1, "R1");
        // R5: power-down applied just after a pixel edge disables at once.
        period(21'h0F0F0F, 1'b0, 1'b0, "R5 power-down");
        period(21'h070707, 1'b0, 1'b0, "R5 power-down");
        // R7: release mid-period; stays off until the next whole word.
        period(21'h1C1C1C, 1'b1, 1'b0, "R7 resume");
        period(21'h0E0E0E, 1'b1, 1'b1, "R7");
        period(21'h00FF00, 1'b1, 1'b1, "R7");
    endtask

    task automatic t_stream;
        logic [W-1:0] v;
        v = 21'h0B00B5;
        for (int i = 0; i < 40; i++) begin
            v = next_rand(v);
            period(v, 1'b1, 1'b1, "R1");
        end
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_powerdown();
        t_stream();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule